// File: doc/BRIEF.md
# Serial-Controlled Analog Switch Controller with Staged Commit

This block is an I2C slave that sets eight switch enables and one general-purpose output. The eight enables belong to four two-way switch pairs, with one A and one B enable per pair. A host writes two data bytes for each command. The first byte names a target and its new setting. The second byte carries a load flag and an active-low clear flag.

Each command first updates a staging copy. When the load flag is high, the staging copy, including every command held since the last commit, is copied to the live outputs in one cycle. A read returns two bytes that show the live outputs. Commands still waiting in the staging copy do not appear in a read.

SCL and SDA are oversampled by the system clock and pass through a synchronizer. The block drives SDA only through an open-drain enable, and it only ever pulls the line low.

Top module: `i2c_sw_ctrl`

## Requirements
- R1: The slave answers only the 7-bit address formed as binary 1010 followed by addr_strap_i[2:0]. If the address does not match, the slave gives no acknowledge, and the data bytes that follow change nothing.
- R2: Data byte 1 selects the target in bits [2:0]. Codes 0 to 3 select pairs 1 to 4, and code 4 selects the GPO. Bit 4 is the A enable, or the GPO level when code 4 is selected. Bit 5 is the B enable. Codes 5 to 7 change nothing in the staging copy.
- R3: When data byte 2 has bit 0 (load) set and bit 1 (clear_n) set, the live outputs take the staging copy after this command is merged in. This happens as soon as the eighth bit of that byte has been clocked, and all held commands land in the same cycle.
- R4: A command with load at 0 and clear_n at 1 leaves sw_en_o and gpo_o unchanged.
- R5: A command with clear_n at 0 clears the live outputs and the staging copy, whatever the load value. All enables go to 0 and gpo_o goes low.
- R6: While rst_ni is low, all enables are 0, gpo_o is low and sda_oe_o is 0.
- R7: A read returns two bytes, and each is followed by an acknowledge from the master. Byte 1 equals sw_en_o, with bit 7 for pair 1 A, bit 6 for pair 1 B, and so on down to bit 0 for pair 4 B. Byte 2 holds gpo_o in bit 3, and its other bits are 0.
- R8: A read shows the live outputs, never the staged values.
- R9: A START or STOP at any point returns the slave to address reception and releases SDA. A write cut short before data byte 2 completes has no effect.
- R10: A third data byte in a write is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap_i | input | 3 | Low three bits of the slave address |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| sw_en_o | output | 8 | Live switch enables, 1 means closed |
| gpo_o | output | 1 | Live general-purpose output |

## Verification
The bench builds up several held commands and then commits them with one loaded write. If a design applied commands one by one, the outputs would change too early. The bench applies a clear after a held command, to catch a design that keeps stale staged bits that later reach the outputs. It reads back while a held command is pending, which exposes status taken from the staging copy. It also aborts a write with STOP and with a repeated START, and sends a third data byte, to catch a design that still applies a half-received or extra command.

// File: rtl/i2c_sw_pkg.sv
package i2c_sw_pkg;
  localparam int unsigned NUM_PAIRS    = 4;
  localparam int unsigned SW_W         = 2 * NUM_PAIRS;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned TGT_W        = $clog2(NUM_PAIRS + 1);
  localparam int unsigned GPO_TGT      = NUM_PAIRS;
  // command field positions
  localparam int unsigned SEL_A_BIT    = 4;
  localparam int unsigned SEL_B_BIT    = 5;
  localparam int unsigned CTL_LOAD_BIT = 0;
  localparam int unsigned CTL_CLRN_BIT = 1;
  localparam int unsigned GPO_STAT_BIT = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_WR, ST_ACK_W, ST_RD, ST_MACK, ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/i2c_sw_sync.sv
module i2c_sw_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_sw_slave.sv
module i2c_sw_slave
  import i2c_sw_pkg::*;
#(
  parameter logic [3:0]  ADDR_HI = 4'b1010,
  parameter int unsigned STRAP_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  stat_hi_i,
  input  logic [BYTE_W-1:0]  stat_lo_i,
  output logic               sda_oe_o,
  output logic               cmd_vld_o,
  output logic [TGT_W-1:0]   cmd_tgt_o,
  output logic               cmd_a_o,
  output logic               cmd_b_o,
  output logic               cmd_load_o,
  output logic               cmd_clrn_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-2:0] txreg_q;
  logic              rw_q, mack_q, oe_q, vld_q;
  logic [1:0]        wr_idx_q, rd_idx_q;
  logic [TGT_W-1:0]  tgt_q;
  logic              a_q, b_q, load_q, clrn_q;
  logic [BYTE_W-1:0] next_tx;

  assign next_tx = (rd_idx_q == 2'd1) ? stat_lo_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      txreg_q   <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      vld_q     <= 1'b0;
      wr_idx_q  <= '0;
      rd_idx_q  <= '0;
      tgt_q     <= '0;
      a_q       <= 1'b0;
      b_q       <= 1'b0;
      load_q    <= 1'b0;
      clrn_q    <= 1'b1;
    end else begin
      vld_q <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        wr_idx_q  <= '0;
        rd_idx_q  <= '0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && bit_cnt_q != CNT_FULL) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && bit_cnt_q == CNT_FULL) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shreg_q[BYTE_W-1:1] == {ADDR_HI, strap_i}) begin
                  oe_q    <= 1'b1;
                  rw_q    <= shreg_q[0];
                  state_q <= ST_ACK_A;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else if (wr_idx_q == 2'd0) begin
                tgt_q    <= shreg_q[TGT_W-1:0];
                a_q      <= shreg_q[SEL_A_BIT];
                b_q      <= shreg_q[SEL_B_BIT];
                wr_idx_q <= 2'd1;
                oe_q     <= 1'b1;
                state_q  <= ST_ACK_W;
              end else if (wr_idx_q == 2'd1) begin
                load_q   <= shreg_q[CTL_LOAD_BIT];
                clrn_q   <= shreg_q[CTL_CLRN_BIT];
                vld_q    <= 1'b1;
                wr_idx_q <= 2'd2;
                oe_q     <= 1'b1;
                state_q  <= ST_ACK_W;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          ST_ACK_A: if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              txreg_q  <= stat_hi_i[BYTE_W-2:0];
              oe_q     <= ~stat_hi_i[BYTE_W-1];
              rd_idx_q <= 2'd1;
              state_q  <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_ACK_W: if (scl_fall_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == CNT_FULL) begin
                oe_q      <= 1'b0;
                bit_cnt_q <= '0;
                state_q   <= ST_MACK;
              end else begin
                oe_q    <= ~txreg_q[BYTE_W-2];
                txreg_q <= {txreg_q[BYTE_W-3:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                txreg_q  <= next_tx[BYTE_W-2:0];
                oe_q     <= ~next_tx[BYTE_W-1];
                rd_idx_q <= 2'd2;
                state_q  <= ST_RD;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign cmd_vld_o  = vld_q;
  assign cmd_tgt_o  = tgt_q;
  assign cmd_a_o    = a_q;
  assign cmd_b_o    = b_q;
  assign cmd_load_o = load_q;
  assign cmd_clrn_o = clrn_q;
endmodule

// File: rtl/i2c_sw_regs.sv
module i2c_sw_regs
  import i2c_sw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  logic [TGT_W-1:0] cmd_tgt_i,
  input  logic             cmd_a_i,
  input  logic             cmd_b_i,
  input  logic             cmd_load_i,
  input  logic             cmd_clrn_i,
  output logic [SW_W-1:0]  sw_en_o,
  output logic             gpo_o
);
  logic [SW_W-1:0] stage_sw_q, live_sw_q;
  logic            stage_gpo_q, live_gpo_q;
  wire  [SW_W-1:0] stage_sw_nxt;
  wire             stage_gpo_nxt;

  // pair p: A enable at SW_W-1-2p, B enable just below
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int unsigned IA = SW_W - 1 - 2 * p;
    localparam int unsigned IB = SW_W - 2 - 2 * p;
    assign stage_sw_nxt[IA] = (cmd_tgt_i == TGT_W'(p)) ? cmd_a_i : stage_sw_q[IA];
    assign stage_sw_nxt[IB] = (cmd_tgt_i == TGT_W'(p)) ? cmd_b_i : stage_sw_q[IB];
  end
  assign stage_gpo_nxt = (cmd_tgt_i == TGT_W'(GPO_TGT)) ? cmd_a_i : stage_gpo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_sw_q  <= '0;
      live_sw_q   <= '0;
      stage_gpo_q <= 1'b0;
      live_gpo_q  <= 1'b0;
    end else if (cmd_vld_i) begin
      if (!cmd_clrn_i) begin
        stage_sw_q  <= '0;
        live_sw_q   <= '0;
        stage_gpo_q <= 1'b0;
        live_gpo_q  <= 1'b0;
      end else begin
        stage_sw_q  <= stage_sw_nxt;
        stage_gpo_q <= stage_gpo_nxt;
        if (cmd_load_i) begin
          live_sw_q  <= stage_sw_nxt;
          live_gpo_q <= stage_gpo_nxt;
        end
      end
    end
  end

  assign sw_en_o = live_sw_q;
  assign gpo_o   = live_gpo_q;
endmodule

// File: rtl/i2c_sw_ctrl.sv
module i2c_sw_ctrl
  import i2c_sw_pkg::*;
#(
  parameter logic [3:0]  ADDR_HI     = 4'b1010,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [2:0]      addr_strap_i,
  output logic            sda_oe_o,
  output logic [SW_W-1:0] sw_en_o,
  output logic            gpo_o
);
  logic              sda_w, rise_w, fall_w, start_w, stop_w;
  logic              cmd_vld_w, cmd_a_w, cmd_b_w, cmd_load_w, cmd_clrn_w;
  logic [TGT_W-1:0]  cmd_tgt_w;
  logic [BYTE_W-1:0] stat_lo_w;

  always_comb begin
    stat_lo_w = '0;
    stat_lo_w[GPO_STAT_BIT] = gpo_o;
  end

  i2c_sw_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2c_sw_slave #(.ADDR_HI(ADDR_HI), .STRAP_W(3)) u_slave (
    .clk_i, .rst_ni,
    .sda_i(sda_w), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
    .start_i(start_w), .stop_i(stop_w), .strap_i(addr_strap_i),
    .stat_hi_i(sw_en_o), .stat_lo_i(stat_lo_w),
    .sda_oe_o,
    .cmd_vld_o(cmd_vld_w), .cmd_tgt_o(cmd_tgt_w), .cmd_a_o(cmd_a_w),
    .cmd_b_o(cmd_b_w), .cmd_load_o(cmd_load_w), .cmd_clrn_o(cmd_clrn_w)
  );

  i2c_sw_regs u_regs (
    .clk_i, .rst_ni,
    .cmd_vld_i(cmd_vld_w), .cmd_tgt_i(cmd_tgt_w), .cmd_a_i(cmd_a_w),
    .cmd_b_i(cmd_b_w), .cmd_load_i(cmd_load_w), .cmd_clrn_i(cmd_clrn_w),
    .sw_en_o, .gpo_o
  );
endmodule

// File: rtl/i2c_sw_ctrl_chk.sv
module i2c_sw_ctrl_chk
  import i2c_sw_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            stop_i,
  input logic            cmd_vld_i,
  input logic            cmd_load_i,
  input logic            cmd_clrn_i,
  input logic            sda_oe_i,
  input logic [SW_W-1:0] sw_en_i,
  input logic            gpo_i
);
  a_r4_hold_without_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_vld_i && (cmd_load_i || !cmd_clrn_i)) |=> ($stable(sw_en_i) && $stable(gpo_i)));

  a_r5_clear_empties_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && !cmd_clrn_i) |=> (sw_en_i == '0 && !gpo_i));

  a_r3_single_commit_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_i |=> !cmd_vld_i);

  a_r9_start_frees_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  a_r9_stop_frees_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);
endmodule

bind i2c_sw_ctrl i2c_sw_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_w), .stop_i(stop_w),
  .cmd_vld_i(cmd_vld_w), .cmd_load_i(cmd_load_w), .cmd_clrn_i(cmd_clrn_w),
  .sda_oe_i(sda_oe_o), .sw_en_i(sw_en_o), .gpo_i(gpo_o)
);

// File: tb/i2c_sw_ctrl_tb.sv
module i2c_sw_ctrl_tb_top;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'hAA;  // 1010_101, write
  localparam logic [7:0] AR = 8'hAB;  // read
  localparam logic [7:0] AX = 8'hA0;  // strap mismatch
  // {byte1, byte2, expected sw_en, expected gpo}
  localparam logic [31:0] VEC [9] = '{
    {8'h10, 8'h03, 8'h80, 8'h00},
    {8'h21, 8'h02, 8'h80, 8'h00},
    {8'h14, 8'h02, 8'h80, 8'h00},
    {8'h33, 8'h03, 8'h93, 8'h01},
    {8'h00, 8'h03, 8'h13, 8'h01},
    {8'h36, 8'h03, 8'h13, 8'h01},
    {8'h12, 8'h02, 8'h13, 8'h01},
    {8'h00, 8'h01, 8'h00, 8'h00},
    {8'h11, 8'h03, 8'h20, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic [7:0] sw_en;
  logic gpo;
  wire  sda_line = sda_drv & ~sda_oe;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  i2c_sw_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_strap_i(3'b101), .sda_oe_o(sda_oe), .sw_en_o(sw_en), .gpo_o(gpo)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qd;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_drv = 1'b1; qd; scl = 1'b1; qd; sda_drv = 1'b0; qd; scl = 1'b0; qd;
  endtask

  task automatic i2c_stop;
    sda_drv = 1'b0; qd; scl = 1'b1; qd; sda_drv = 1'b1; qd;
  endtask

  task automatic i2c_bit(input logic b, output logic r);
    sda_drv = b; qd; scl = 1'b1; qd; r = sda_line; qd; scl = 1'b0; qd;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) i2c_bit(d[i], r);
    i2c_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      i2c_bit(1'b1, r);
      d[i] = r;
    end
    i2c_bit(~mack, r);
  endtask

  task automatic write_cmd(input logic [7:0] a, input logic [7:0] b1, input logic [7:0] b2,
                           output logic [2:0] acks);
    i2c_start;
    wr_byte(a, acks[2]);
    wr_byte(b1, acks[1]);
    wr_byte(b2, acks[0]);
    i2c_stop;
  endtask

  task automatic read_stat(output logic [15:0] st);
    logic a;
    i2c_start;
    wr_byte(AR, a);
    rd_byte(1'b1, st[15:8]);
    rd_byte(1'b0, st[7:0]);
    i2c_stop;
    check("R1 read address ack", {15'd0, a}, 16'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0]  acks;
    logic [15:0] st;
    logic        a, r;
    repeat (5) @(negedge clk);
    check("R6 reset sw_en", {8'd0, sw_en}, 16'h0000);
    check("R6 reset gpo/oe", {14'd0, gpo, sda_oe}, 16'h0000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table: staging, commit, clear (R2 R3 R4 R5)
    foreach (VEC[k]) begin
      write_cmd(AW, VEC[k][31:24], VEC[k][23:16], acks);
      check("R1 write acks", {13'd0, acks}, 16'h0007);
      check("R2/R3/R4/R5 sw_en", {8'd0, sw_en}, {8'd0, VEC[k][15:8]});
      check("R2/R3/R4/R5 gpo", {15'd0, gpo}, {15'd0, VEC[k][0]});
    end

    // R7 readback
    read_stat(st);
    check("R7 status gpo low", st, 16'h2000);
    write_cmd(AW, 8'h14, 8'h03, acks);
    read_stat(st);
    check("R7 status gpo high", st, 16'h2008);

    // R8 staged command invisible on readback
    write_cmd(AW, 8'h13, 8'h02, acks);
    read_stat(st);
    check("R8 status ignores staging", st, 16'h2008);
    check("R8 live unchanged", {8'd0, sw_en}, 16'h0020);

    // R1 wrong address: no ack, no effect
    write_cmd(AX, 8'h10, 8'h03, acks);
    check("R1 mismatch no ack", {15'd0, acks[2]}, 16'h0000);
    check("R1 mismatch no effect", {8'd0, sw_en}, 16'h0020);

    // R9 STOP after first data byte
    i2c_start; wr_byte(AW, a); wr_byte(8'h10, a); i2c_stop;
    // R9 repeated START in the middle of byte 2
    i2c_start; wr_byte(AW, a); wr_byte(8'h10, a);
    for (int i = 0; i < 4; i++) i2c_bit(1'b1, r);
    write_cmd(AW, 8'h36, 8'h03, acks);
    check("R9 abort leaves only staged pair4A", {8'd0, sw_en}, 16'h0022);
    check("R9 gpo kept", {15'd0, gpo}, 16'h0001);

    // R10 third data byte
    i2c_start; wr_byte(AW, a); wr_byte(8'h00, a); wr_byte(8'h03, a);
    wr_byte(8'h10, a); i2c_stop;
    check("R10 third byte nack", {15'd0, a}, 16'h0000);
    check("R10 third byte ignored", {8'd0, sw_en}, 16'h0022);

    // R5 clear with load low
    write_cmd(AW, 8'h00, 8'h00, acks);
    check("R5 clear without load sw", {8'd0, sw_en}, 16'h0000);
    check("R5 clear without load gpo", {15'd0, gpo}, 16'h0000);

    // R6 async reset mid-run
    write_cmd(AW, 8'h10, 8'h03, acks);
    check("R3 commit before reset", {8'd0, sw_en}, 16'h0080);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 async reset clears", {7'd0, sw_en, gpo}, 16'h0000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    write_cmd(AW, 8'h30, 8'h03, acks);
    check("R3 works after reset", {8'd0, sw_en}, 16'h00C0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule